// File: doc/BRIEF.md
# Carry-Based Bit Manipulation Unit

This unit performs single-bit operations on one byte, with a one-bit carry flag used as an accumulator. A three-bit bit number picks one bit of the byte. That bit number comes either from an immediate field or from the low bits of a register value. The unit can set, clear, invert or test the selected bit. It can load that bit into carry, or store carry into that bit, and either direction has an inverted form. It can also fold the bit into carry with AND, OR or XOR, each with a form that uses the complemented bit.

Each valid input produces exactly one registered result one clock later. The result is the possibly modified byte, a write-enable that tells the surrounding datapath whether to write the byte back, and the new carry and zero flags. Fetching the operand and handling addressing modes are left to the logic around the unit.

Top module: `carry_bit_unit`

## Requirements
- R1: While reset is asserted and right after it, out_valid, out_we, out_byte, out_carry and out_zero are all 0.
- R2: out_valid is 1 in the cycle after a cycle with in_valid high, and 0 in the cycle after a cycle with in_valid low.
- R3: Opcode 0 forces the selected bit to 1, opcode 1 forces it to 0, and opcode 2 inverts it. All other bits are unchanged, out_we is 1, and the carry and zero flags pass through.
- R4: Opcode 3 (test) sets out_zero to the complement of the selected bit. out_byte equals in_byte, out_we is 0, and carry passes through.
- R5: Opcode 4 copies the selected bit into out_carry, and opcode 5 copies its complement. out_byte equals in_byte, out_we is 0, and zero passes through.
- R6: Opcode 6 writes carry into the selected bit, and opcode 7 writes the complement of carry. All other bits are unchanged, out_we is 1, and both flags pass through.
- R7: Opcodes 8, 10 and 12 set out_carry to carry AND, OR and XOR the selected bit. Opcodes 9, 11 and 13 do the same with the complemented bit. out_byte equals in_byte, out_we is 0, and zero passes through.
- R8: With in_use_reg at 1, the bit number is the low three bits of in_regval and the upper bits are ignored. With in_use_reg at 0, the bit number is in_imm.
- R9: An opcode of 14 or 15 has no effect: out_byte equals in_byte, out_we is 0, and both flags pass through. A register-sourced bit number combined with an opcode above 3 also has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operation is valid this cycle |
| in_op | input | 4 | Opcode (see requirements) |
| in_byte | input | 8 | Operand byte |
| in_imm | input | 3 | Immediate bit number |
| in_regval | input | 8 | Register value whose low bits may supply the bit number |
| in_use_reg | input | 1 | 1: bit number from in_regval, 0: from in_imm |
| in_carry | input | 1 | Current carry flag |
| in_zero | input | 1 | Current zero flag |
| out_valid | output | 1 | Result valid |
| out_byte | output | 8 | Resulting byte |
| out_we | output | 1 | Write the byte back |
| out_carry | output | 1 | New carry flag |
| out_zero | output | 1 | New zero flag |

## Verification
The bench builds the unit with its default 8-bit byte. This keeps the bit number at three bits, so every opcode, both bit-number sources, every bit position and every combination of carry and zero inputs can be swept over several byte patterns. The upper bits of the register value are set to differ from the selected position, which exposes any decode that looks beyond the low three bits. The immediate and register fields always disagree, so choosing the wrong source is visible. Reserved opcodes and forbidden register sourcing fall inside the same sweep.

// File: rtl/carry_bit_unit.sv
module carry_bit_unit #(
  parameter int DATA_W = 8,
  parameter int OP_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [OP_W-1:0]           in_op,
  input  logic [DATA_W-1:0]         in_byte,
  input  logic [$clog2(DATA_W)-1:0] in_imm,
  input  logic [DATA_W-1:0]         in_regval,
  input  logic                      in_use_reg,
  input  logic                      in_carry,
  input  logic                      in_zero,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         out_byte,
  output logic                      out_we,
  output logic                      out_carry,
  output logic                      out_zero
);
  localparam int BW = $clog2(DATA_W);

  logic [BW-1:0]     pos;
  logic              bitv;
  logic              legal;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] nb;
  logic              nwe, nc, nz;

  assign pos   = in_use_reg ? in_regval[BW-1:0] : in_imm;
  assign bitv  = in_byte[pos];
  assign mask  = {{(DATA_W-1){1'b0}}, 1'b1} << pos;
  assign legal = (in_op <= OP_W'(13)) && (!in_use_reg || in_op <= OP_W'(3));

  always_comb begin
    nb  = in_byte;
    nwe = 1'b0;
    nc  = in_carry;
    nz  = in_zero;
    if (legal) begin
      case (in_op)
        OP_W'(0):  begin nb = in_byte | mask;  nwe = 1'b1; end
        OP_W'(1):  begin nb = in_byte & ~mask; nwe = 1'b1; end
        OP_W'(2):  begin nb = in_byte ^ mask;  nwe = 1'b1; end
        OP_W'(3):  nz = ~bitv;
        OP_W'(4):  nc = bitv;
        OP_W'(5):  nc = ~bitv;
        OP_W'(6):  begin nb = in_carry  ? (in_byte | mask) : (in_byte & ~mask); nwe = 1'b1; end
        OP_W'(7):  begin nb = !in_carry ? (in_byte | mask) : (in_byte & ~mask); nwe = 1'b1; end
        OP_W'(8):  nc = in_carry & bitv;
        OP_W'(9):  nc = in_carry & ~bitv;
        OP_W'(10): nc = in_carry | bitv;
        OP_W'(11): nc = in_carry | ~bitv;
        OP_W'(12): nc = in_carry ^ bitv;
        OP_W'(13): nc = in_carry ^ ~bitv;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_we    <= 1'b0;
      out_carry <= 1'b0;
      out_zero  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_byte  <= nb;
        out_we    <= nwe;
        out_carry <= nc;
        out_zero  <= nz;
      end
    end
  end
endmodule

// File: rtl/carry_bit_unit_checks.sv
module carry_bit_unit_checks #(
  parameter int DATA_W = 8,
  parameter int OP_W   = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic [OP_W-1:0]           in_op,
  input logic [DATA_W-1:0]         in_byte,
  input logic                      in_use_reg,
  input logic                      in_carry,
  input logic                      in_zero,
  input logic                      out_valid,
  input logic [DATA_W-1:0]         out_byte,
  input logic                      out_we,
  input logic                      out_carry,
  input logic                      out_zero
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r3_one_bit_changes: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ($countones(out_byte ^ $past(in_byte)) <= 1));
  a_r4_test_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_W'(3)) |=> (!out_we && out_carry == $past(in_carry)));
  a_r7_logic_keeps_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op >= OP_W'(8) && in_op <= OP_W'(13)) |=> (!out_we && out_zero == $past(in_zero)));
  a_r9_forbidden_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op >= OP_W'(14) || (in_use_reg && in_op >= OP_W'(4)))) |=>
    (!out_we && out_byte == $past(in_byte) && out_carry == $past(in_carry) && out_zero == $past(in_zero)));
  a_r9_no_write_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid ##1 !out_we) |-> (out_byte == $past(in_byte)));
endmodule

bind carry_bit_unit carry_bit_unit_checks #(.DATA_W(DATA_W), .OP_W(OP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_byte(in_byte),
  .in_use_reg(in_use_reg), .in_carry(in_carry), .in_zero(in_zero),
  .out_valid(out_valid), .out_byte(out_byte), .out_we(out_we),
  .out_carry(out_carry), .out_zero(out_zero));

// File: tb/test_carry_bit_unit.sv
module test_carry_bit_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] in_op = '0;
  logic [7:0] in_byte = '0;
  logic [2:0] in_imm = '0;
  logic [7:0] in_regval = '0;
  logic       in_use_reg = 1'b0;
  logic       in_carry = 1'b0;
  logic       in_zero = 1'b0;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       out_we;
  logic       out_carry;
  logic       out_zero;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  carry_bit_unit i_carry_bit_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_byte(in_byte),
    .in_imm(in_imm), .in_regval(in_regval), .in_use_reg(in_use_reg),
    .in_carry(in_carry), .in_zero(in_zero), .out_valid(out_valid),
    .out_byte(out_byte), .out_we(out_we), .out_carry(out_carry), .out_zero(out_zero));

  // returns {we, carry, zero, byte}
  function automatic logic [10:0] model(input int op, input bit ureg, input int p,
                                        input logic [7:0] b, input bit c, input bit z);
    logic [7:0] nb = b;
    bit we = 0, nc = c, nz = z;
    bit v = b[p];
    if (op <= 13 && !(ureg && op > 3)) begin
      case (op)
        0: begin nb[p] = 1'b1; we = 1; end
        1: begin nb[p] = 1'b0; we = 1; end
        2: begin nb[p] = ~v;   we = 1; end
        3: nz = !v;
        4: nc = v;
        5: nc = !v;
        6: begin nb[p] = c;  we = 1; end
        7: begin nb[p] = !c; we = 1; end
        8: nc = c & v;
        9: nc = c & !v;
        10: nc = c | v;
        11: nc = c | !v;
        12: nc = c ^ v;
        13: nc = c ^ !v;
        default: ;
      endcase
    end
    return {we, nc, nz, nb};
  endfunction

  function automatic string tag(input int op, input bit ureg);
    if (op > 13 || (ureg && op > 3)) return "R9";
    if (ureg) return "R8";
    if (op <= 2) return "R3";
    if (op == 3) return "R4";
    if (op <= 5) return "R5";
    if (op <= 7) return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    logic [7:0] pats [4];
    logic [10:0] exp;
    logic [10:0] pend_exp;
    string pend_tag;
    bit pend = 0;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {out_valid, out_we, out_carry, out_zero, out_byte}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {out_valid, out_we, out_carry, out_zero, out_byte}, '0);
    for (int op = 0; op < 16; op++) begin
      for (int ur = 0; ur < 2; ur++) begin
        for (int p = 0; p < 8; p++) begin
          for (int bi = 0; bi < 4; bi++) begin
            for (int cz = 0; cz < 4; cz++) begin
              in_valid   = 1'b1;
              in_op      = 4'(op);
              in_byte    = pats[bi];
              in_use_reg = ur[0];
              in_carry   = cz[1];
              in_zero    = cz[0];
              if (ur != 0) begin
                in_regval = {5'((~p) ^ (bi * 7)), 3'(p)};
                in_imm    = 3'(p ^ 5);
              end else begin
                in_imm    = 3'(p);
                in_regval = {5'(bi * 3), 3'(p ^ 3)};
              end
              exp = model(op, ur[0], p, pats[bi], cz[1], cz[0]);
              @(negedge clk);
              check("R2", {31'd0, out_valid}, 32'd1);
              check(tag(op, ur[0]), {21'd0, out_we, out_carry, out_zero, out_byte}, {21'd0, exp});
            end
          end
        end
      end
      in_valid = 1'b0;
      @(negedge clk);
      check("R2", {31'd0, out_valid}, 32'd0);
    end
    if (pend) pend_tag = "";
    pend_exp = '0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule